// File: doc/BRIEF.md
# Single-Precision Compare and Min/Max Unit

This unit takes two binary32 operands and a 4-bit operation code. It produces one result per operation: a minimum or maximum, a less-than, less-or-equal or equality flag, and an invalid-operation exception flag. The inputs are sampled on a rising clock edge, and all three outputs are registered. A result therefore shows up one cycle after its operands are presented. A new operation can start on every cycle.

Min and max come in two forms:
- The number-preferring form returns the numeric operand when only one operand is NaN.
- The NaN-propagating form returns the canonical NaN whenever any operand is NaN.

The ordered comparisons come in two forms:
- The signaling form flags invalid on any NaN.
- The quiet form never flags invalid, not even for a signaling NaN.

Equality is always quiet. It flags invalid only for signaling NaNs.

Top module: `fp_cmp_minmax`

## Requirements
- R1: While rst_n is low and after its release, before the first operation, res_fp, res_int and invalid are all 0.
- R2: Operation codes are: 0 MIN, 1 MAX (number-preferring), 2 MIN, 3 MAX (NaN-propagating), 4 EQ, 5 LT, 6 LE (signaling), 7 LT, 8 LE (quiet). Outputs reflect the operands and code sampled at the previous rising edge.
- R3: For non-NaN operands, min returns the smaller and max returns the larger operand bit-exactly. This holds for negative values and infinities.
- R4: In codes 0/1, if exactly one operand is NaN the result is the other operand unchanged. If both operands are NaN the result is 0x7FC00000.
- R5: In codes 2/3, if either operand is NaN the result is 0x7FC00000, and no input payload passes through.
- R6: For all min/max codes, -0.0 orders below +0.0. So min(+0,-0) is 0x80000000 and max(-0,+0) is 0x00000000.
- R7: Min/max raise invalid exactly when an operand is a signaling NaN, meaning exponent all ones, bit 22 clear and a non-zero fraction. A quiet NaN (bit 22 set) does not raise invalid.
- R8: Codes 5/6 return 0 and raise invalid when either operand is any NaN. For comparisons, -0.0 equals +0.0: LE(-0,+0) is 1 and LT(-0,+0) is 0.
- R9: Codes 7/8 give the same result bit as 5/6 but never raise invalid.
- R10: Code 4 returns 1 for equal values, including -0 versus +0. It returns 0 if any operand is NaN, and raises invalid only for a signaling NaN.
- R11: Min/max codes drive res_int to 0. Comparison codes drive res_fp to 0. Codes 9 to 15 drive all outputs to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op | input | 4 | Operation code |
| a | input | 32 | First binary32 operand |
| b | input | 32 | Second binary32 operand |
| res_fp | output | 32 | Min/max result |
| res_int | output | 1 | Comparison result |
| invalid | output | 1 | Invalid-operation flag |

## Verification
Min/max is exercised with four groups of operand pairs:
- Mixed-sign, same-sign-negative and infinite pairs, which separate a correct sign-magnitude ordering from a plain unsigned compare.
- Signed zeros in both operand orders, which expose a design that treats the zeros as equal and returns a fixed operand.
- A quiet NaN paired with a number, run in both families, which distinguishes number preference from NaN propagation. The quiet NaN carries a non-canonical payload, which reveals any payload leak.
- Quiet and signaling NaNs through every comparison code, which separate the signaling, quiet and equality flag rules.

// File: rtl/fp_cmp_minmax.sv
`timescale 1ns/1ps
module fp_cmp_minmax (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [3:0]  op,
  input  logic [31:0] a,
  input  logic [31:0] b,
  output logic [31:0] res_fp,
  output logic        res_int,
  output logic        invalid
);
  localparam logic [3:0]  OP_MIN  = 4'd0;
  localparam logic [3:0]  OP_MAX  = 4'd1;
  localparam logic [3:0]  OP_MINP = 4'd2;
  localparam logic [3:0]  OP_MAXP = 4'd3;
  localparam logic [3:0]  OP_EQ   = 4'd4;
  localparam logic [3:0]  OP_LT   = 4'd5;
  localparam logic [3:0]  OP_LE   = 4'd6;
  localparam logic [3:0]  OP_LTQ  = 4'd7;
  localparam logic [3:0]  OP_LEQ  = 4'd8;
  localparam logic [31:0] QNAN    = 32'h7FC0_0000;

  logic a_nan, b_nan, a_snan, b_snan, any_nan, any_snan, both_zero;
  logic tot_lt, ord_lt, ord_eq;
  logic [31:0] lo_val, hi_val;
  logic [31:0] nxt_fp;
  logic        nxt_int, nxt_inv;

  assign a_nan     = (&a[30:23]) && (|a[22:0]);
  assign b_nan     = (&b[30:23]) && (|b[22:0]);
  assign a_snan    = a_nan && !a[22];
  assign b_snan    = b_nan && !b[22];
  assign any_nan   = a_nan || b_nan;
  assign any_snan  = a_snan || b_snan;
  assign both_zero = ~|{a[30:0], b[30:0]};

  assign tot_lt = (a[31] != b[31]) ? a[31]
                : (a[31] ? (a[30:0] > b[30:0]) : (a[30:0] < b[30:0]));
  assign ord_lt = tot_lt && !both_zero;
  assign ord_eq = (a == b) || both_zero;

  assign lo_val = tot_lt ? a : b;
  assign hi_val = tot_lt ? b : a;

  always_comb begin
    nxt_fp  = '0;
    nxt_int = 1'b0;
    nxt_inv = 1'b0;
    case (op)
      OP_MIN, OP_MAX: begin
        nxt_inv = any_snan;
        if (a_nan && b_nan)  nxt_fp = QNAN;
        else if (a_nan)      nxt_fp = b;
        else if (b_nan)      nxt_fp = a;
        else                 nxt_fp = (op == OP_MIN) ? lo_val : hi_val;
      end
      OP_MINP, OP_MAXP: begin
        nxt_inv = any_snan;
        if (any_nan)         nxt_fp = QNAN;
        else                 nxt_fp = (op == OP_MINP) ? lo_val : hi_val;
      end
      OP_EQ: begin
        nxt_int = !any_nan && ord_eq;
        nxt_inv = any_snan;
      end
      OP_LT: begin
        nxt_int = !any_nan && ord_lt;
        nxt_inv = any_nan;
      end
      OP_LE: begin
        nxt_int = !any_nan && (ord_lt || ord_eq);
        nxt_inv = any_nan;
      end
      OP_LTQ: nxt_int = !any_nan && ord_lt;
      OP_LEQ: nxt_int = !any_nan && (ord_lt || ord_eq);
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_fp  <= '0;
      res_int <= 1'b0;
      invalid <= 1'b0;
    end else begin
      res_fp  <= nxt_fp;
      res_int <= nxt_int;
      invalid <= nxt_inv;
    end
  end
endmodule

// File: rtl/fp_cmp_minmax_chk.sv
`timescale 1ns/1ps
module fp_cmp_minmax_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [3:0]  op,
  input logic [31:0] a,
  input logic [31:0] b,
  input logic [31:0] res_fp,
  input logic        res_int,
  input logic        invalid
);
  logic seen;
  always_ff @(posedge clk) begin
    if (!rst_n) seen <= 1'b0;
    else        seen <= 1'b1;
  end

  logic an, bn, aq, bq;
  assign an = (&a[30:23]) && (|a[22:0]);
  assign bn = (&b[30:23]) && (|b[22:0]);
  assign aq = an && a[22];
  assign bq = bn && b[22];

  a_r5_nanprop_canonical: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && $past(rst_n) && $past((op == 4'd2 || op == 4'd3) && (an || bn))) |-> res_fp == 32'h7FC0_0000);

  a_r4_prefers_number: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && $past(rst_n) && $past(op <= 4'd1 && an && !bn)) |-> res_fp == $past(b));

  a_r9_quiet_never_invalid: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && $past(rst_n) && $past(op == 4'd7 || op == 4'd8)) |-> !invalid);

  a_r8_nan_compare_false: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && $past(rst_n) && $past(op >= 4'd4 && op <= 4'd8 && (an || bn))) |-> !res_int);

  a_r7_qnan_quiet_minmax: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && $past(rst_n) && $past(op <= 4'd3 && (!an || aq) && (!bn || bq))) |-> !invalid);

  a_r11_minmax_int_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && $past(rst_n) && $past(op <= 4'd3)) |-> !res_int);
endmodule

bind fp_cmp_minmax fp_cmp_minmax_chk i_chk (
  .clk(clk), .rst_n(rst_n), .op(op), .a(a), .b(b),
  .res_fp(res_fp), .res_int(res_int), .invalid(invalid)
);

// File: tb/test_fp_cmp_minmax.sv
`timescale 1ns/1ps
module test_fp_cmp_minmax;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  op = '0;
  logic [31:0] a = '0, b = '0;
  logic [31:0] res_fp;
  logic        res_int, invalid;
  int total = 0, fails = 0;
  bit done = 0;

  localparam logic [31:0] P1 = 32'h3F80_0000, P2 = 32'h4000_0000;
  localparam logic [31:0] N1 = 32'hBF80_0000, N2 = 32'hC000_0000;
  localparam logic [31:0] PZ = 32'h0000_0000, NZ = 32'h8000_0000;
  localparam logic [31:0] PINF = 32'h7F80_0000, NINF = 32'hFF80_0000;
  localparam logic [31:0] QN = 32'h7FC0_1234, SN = 32'h7F80_0001, CN = 32'h7FC0_0000;

  always #2 clk = ~clk;

  fp_cmp_minmax i_fp_cmp_minmax (.clk(clk), .rst_n(rst_n), .op(op), .a(a), .b(b),
    .res_fp(res_fp), .res_int(res_int), .invalid(invalid));

  task automatic chk(input string tag, input logic [31:0] efp, input logic eint, input logic einv);
    total++;
    if (res_fp !== efp || res_int !== eint || invalid !== einv) begin
      fails++;
      $display("FAIL %s: got fp=%h int=%b inv=%b, expected fp=%h int=%b inv=%b",
               tag, res_fp, res_int, invalid, efp, eint, einv);
    end
  endtask

  task automatic run(input string tag, input logic [3:0] o, input logic [31:0] x, input logic [31:0] y,
                     input logic [31:0] efp, input logic eint, input logic einv);
    @(negedge clk);
    op = o; a = x; b = y;
    @(negedge clk);
    chk(tag, efp, eint, einv);
  endtask

  task automatic t_reset;
    op = 4'd1; a = P2; b = P1;
    repeat (3) @(negedge clk);
    chk("R1 during reset", '0, 1'b0, 1'b0);
    rst_n = 1'b1;
    op = 4'd9;
    @(negedge clk);
    chk("R1 after release", '0, 1'b0, 1'b0);
  endtask

  task automatic t_latency;
    @(negedge clk);
    op = 4'd1; a = N1; b = P2;
    @(posedge clk); #1;
    op = 4'd0; a = P1; b = P2;
    @(negedge clk);
    chk("R2 one-cycle latency", P2, 1'b0, 1'b0);
  endtask

  task automatic t_ordering;
    run("R3 min mixed sign", 4'd0, N2, P1, N2, 1'b0, 1'b0);
    run("R3 min both negative", 4'd0, N1, N2, N2, 1'b0, 1'b0);
    run("R3 max both negative", 4'd1, N1, N2, N1, 1'b0, 1'b0);
    run("R3 max infinities", 4'd3, NINF, PINF, PINF, 1'b0, 1'b0);
    run("R3 min positive", 4'd2, P2, P1, P1, 1'b0, 1'b0);
  endtask

  task automatic t_families;
    run("R4 min qnan first", 4'd0, QN, P1, P1, 1'b0, 1'b0);
    run("R4 max qnan second", 4'd1, N2, QN, N2, 1'b0, 1'b0);
    run("R4 both nan canon", 4'd0, QN, QN, CN, 1'b0, 1'b0);
    run("R5 minp qnan", 4'd2, QN, P1, CN, 1'b0, 1'b0);
    run("R5 maxp qnan second", 4'd3, N1, QN, CN, 1'b0, 1'b0);
  endtask

  task automatic t_signed_zero;
    run("R6 min +0,-0", 4'd0, PZ, NZ, NZ, 1'b0, 1'b0);
    run("R6 max -0,+0", 4'd1, NZ, PZ, PZ, 1'b0, 1'b0);
    run("R6 minp -0,+0", 4'd2, NZ, PZ, NZ, 1'b0, 1'b0);
    run("R6 maxp +0,-0", 4'd3, PZ, NZ, PZ, 1'b0, 1'b0);
  endtask

  task automatic t_minmax_flags;
    run("R7 min snan", 4'd0, SN, P1, P1, 1'b0, 1'b1);
    run("R7 maxp snan", 4'd3, P1, SN, CN, 1'b0, 1'b1);
    run("R7 minp qnan no flag", 4'd2, QN, P1, CN, 1'b0, 1'b0);
  endtask

  task automatic t_signaling_cmp;
    run("R8 lt true", 4'd5, N1, P1, '0, 1'b1, 1'b0);
    run("R8 lt false", 4'd5, P2, P1, '0, 1'b0, 1'b0);
    run("R8 le -0,+0", 4'd6, NZ, PZ, '0, 1'b1, 1'b0);
    run("R8 lt -0,+0", 4'd5, NZ, PZ, '0, 1'b0, 1'b0);
    run("R8 lt qnan", 4'd5, QN, P1, '0, 1'b0, 1'b1);
    run("R8 le qnan", 4'd6, P1, QN, '0, 1'b0, 1'b1);
  endtask

  task automatic t_quiet_cmp;
    run("R9 ltq true", 4'd7, N2, N1, '0, 1'b1, 1'b0);
    run("R9 leq equal", 4'd8, P1, P1, '0, 1'b1, 1'b0);
    run("R9 ltq snan", 4'd7, SN, P1, '0, 1'b0, 1'b0);
    run("R9 leq qnan", 4'd8, P1, QN, '0, 1'b0, 1'b0);
  endtask

  task automatic t_equal;
    run("R10 eq same", 4'd4, N2, N2, '0, 1'b1, 1'b0);
    run("R10 eq zeros", 4'd4, PZ, NZ, '0, 1'b1, 1'b0);
    run("R10 eq differ", 4'd4, P1, P2, '0, 1'b0, 1'b0);
    run("R10 eq qnan", 4'd4, QN, QN, '0, 1'b0, 1'b0);
    run("R10 eq snan", 4'd4, P1, SN, '0, 1'b0, 1'b1);
  endtask

  task automatic t_unused;
    run("R11 code 9", 4'd9, SN, QN, '0, 1'b0, 1'b0);
    run("R11 code 15", 4'd15, N1, P1, '0, 1'b0, 1'b0);
    run("R11 compare fp zero", 4'd5, N1, P1, '0, 1'b1, 1'b0);
  endtask

  initial begin
    t_reset();
    t_latency();
    t_ordering();
    t_families();
    t_signed_zero();
    t_minmax_flags();
    t_signaling_cmp();
    t_quiet_cmp();
    t_equal();
    t_unused();
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule